// File: doc/BRIEF.md
# Chained DAC Command Sequencer

This block is a host-side serial master for a string of quad 8-bit DACs that share one chip select, one serial clock and one data line. The DACs are wired in series: each passes its own 12-bit shift register on to the next. Each request carries one 12-bit word per device and a skip mask. The sequencer builds one stream of `12*N_DEV` bits. Skipped devices get a no-op word, and the word for the device farthest from the host goes out first. The sequencer holds chip select low, clocks the stream out with the clock idle low, and then raises chip select. Every device in the chain acts on its word at that same edge.

A second request type runs a coordinated update. It sends five back-to-back transactions. Each of the first four loads one channel's input register in every selected device without changing any output. The fifth sends a software-load word, so all outputs of all selected devices change together at the last rising edge of chip select.

Bits that come back from the far end of the chain are sampled on each rising clock edge and presented as a readback vector. The serial half period and the chip-select setup and hold times are parameters counted in system clock cycles.

Top module: `dac_chain_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `req_ready` is 1, `done` is 0 and `rdback` is all zeros.
- R2: `sclk` idles low and is high only while `cs_n` is low.
- R3: Each transaction clocks out exactly `12*N_DEV` bits, MSB first. The word of device `N_DEV-1` (farthest from the host) goes first and the word of device 0 goes last. Device d's word is `req_words[d*12 +: 12]`.
- R4: A device whose `req_skip` bit is 1 receives the no-op word 12'h400 (bits [11:10] address, [9:8] control; address 01, control 00) instead of its request word.
- R5: `mosi` changes only after a falling `sclk` edge and holds steady for the whole high phase of `sclk`.
- R6: The first rising `sclk` edge follows the fall of `cs_n` by exactly `CS_SETUP+CLK_DIV` system clock cycles, and each `sclk` high phase lasts `CLK_DIV` cycles.
- R7: With `req_seq`=1, five transactions run. In transaction k (k=0..3), each non-skipped device d gets `{k[1:0], 2'b01, req_chan[d*32+k*8 +: 8]}`. In transaction 4 it gets the software-load word 12'h200. Skipped devices get 12'h400 in all five.
- R8: `done` is a one-cycle pulse, raised one cycle after `cs_n` rises at the end of the request's last transaction. It is raised once per request.
- R9: `miso` is sampled at each rising `sclk` edge and shifted into `rdback` at the LSB. After a transaction, `rdback` holds the bits returned in it, with the first bit received at the MSB.
- R10: `req_ready` is 1 only when the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_seq | input | 1 | 0: single chained transaction, 1: five-step coordinated update |
| req_words | input | 12*N_DEV | Per-device command words, device d at [d*12 +: 12] |
| req_skip | input | N_DEV | Per-device skip mask (1 = send no-op) |
| req_chan | input | 32*N_DEV | Coordinated-update data, device d channel c at [d*32+c*8 +: 8] |
| cs_n | output | 1 | Shared chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the nearest device |
| miso | input | 1 | Serial data returned from the farthest device |
| rdback | output | 12*N_DEV | Bits returned during the last transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the coordinated update: the fifth transaction must show up only after four correctly addressed preloads, and `done` must stay low through the four intermediate chip-select rises. The bench models the chain as one shift register clocked by `sclk`. It logs the register's contents at every rising edge of `cs_n`, so every transaction's per-device words can be compared. Both request types are swept over every skip mask of a three-device chain. The readback is checked by feeding the chain's own previous contents back on `miso`.

// File: rtl/dac_chain_seq.sv
module dac_chain_seq #(
  parameter int N_DEV    = 3,
  parameter int CLK_DIV  = 2,
  parameter int CS_SETUP = 3,
  parameter int CS_HOLD  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_seq,
  input  logic [12*N_DEV-1:0]   req_words,
  input  logic [N_DEV-1:0]      req_skip,
  input  logic [32*N_DEV-1:0]   req_chan,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic [12*N_DEV-1:0]   rdback,
  output logic                  done
);
  localparam int TOT  = 12 * N_DEV;
  localparam int BW   = $clog2(TOT + 1);
  localparam int CMAX = (CLK_DIV > CS_SETUP) ? ((CLK_DIV > CS_HOLD) ? CLK_DIV : CS_HOLD)
                                             : ((CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [11:0] NOP_W  = 12'h400;
  localparam logic [11:0] LOAD_W = 12'h200;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bits;
  logic [2:0]           frame;
  logic [TOT-1:0]       shreg, rx;
  logic [TOT-1:0]       lw;
  logic [N_DEV-1:0]     lsk;
  logic [32*N_DEV-1:0]  lch;
  logic                 lsq;

  function automatic logic [TOT-1:0] build(input logic [TOT-1:0] w, input logic [N_DEV-1:0] sk,
                                           input logic [32*N_DEV-1:0] ch, input logic sq,
                                           input logic [2:0] f);
    logic [TOT-1:0] r;
    logic [11:0]    x;
    r = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (sk[d])        x = NOP_W;
      else if (!sq)     x = w[d*12 +: 12];
      else if (f == 3'd4) x = LOAD_W;
      else              x = {f[1:0], 2'b01, ch[d*32 + int'(f[1:0])*8 +: 8]};
      r[d*12 +: 12] = x;
    end
    return r;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign mosi      = shreg[TOT-1];
  assign rdback    = rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bits <= '0; frame <= '0;
      shreg <= '0; rx <= '0; lw <= '0; lsk <= '0; lch <= '0; lsq <= 1'b0;
      cs_n <= 1'b1; sclk <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          lw <= req_words; lsk <= req_skip; lch <= req_chan; lsq <= req_seq;
          frame <= '0;
          shreg <= build(req_words, req_skip, req_chan, req_seq, 3'd0);
          cs_n <= 1'b0; cnt <= '0; st <= S_SETUP;
        end
        S_SETUP: if (cnt == CW'(CS_SETUP - 1)) begin
          cnt <= '0; bits <= '0; st <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (cnt == CW'(CLK_DIV - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx <= {rx[TOT-2:0], miso};
          end else begin
            sclk <= 1'b0;
            shreg <= {shreg[TOT-2:0], 1'b0};
            if (bits == BW'(TOT - 1)) st <= S_HOLD;
            else bits <= bits + 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (cnt == CW'(CS_HOLD - 1)) begin
          cnt <= '0; cs_n <= 1'b1; st <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: if (!lsq || frame == 3'd4) begin
          done <= 1'b1; st <= S_IDLE;
        end else if (cnt == CW'(CS_HOLD - 1)) begin
          cnt <= '0;
          frame <= frame + 1'b1;
          shreg <= build(lw, lsk, lch, lsq, 3'(frame + 1'b1));
          cs_n <= 1'b0; st <= S_SETUP;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n); // R2
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi)); // R5
  AST_CS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !sclk); // R6
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && $past(cs_n) && !$past(cs_n, 2)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> cs_n && !sclk); // R10
endmodule

// File: tb/tb_dac_chain_seq.sv
module tb_dac_chain_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV = 3, CLK_DIV = 2, CS_SETUP = 3, CS_HOLD = 2;
  localparam int TOT = 12 * N_DEV;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_seq = 0, miso;
  logic [TOT-1:0] req_words = '0;
  logic [N_DEV-1:0] req_skip = '0;
  logic [32*N_DEV-1:0] req_chan = '0;
  logic req_ready, cs_n, sclk, mosi, done;
  logic [TOT-1:0] rdback;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_seq #(.N_DEV(N_DEV), .CLK_DIV(CLK_DIV), .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_seq(req_seq),
    .req_words(req_words), .req_skip(req_skip), .req_chan(req_chan), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .rdback(rdback), .done(done));

  logic [TOT-1:0] chain = '0;
  logic [TOT-1:0] flog [0:63];
  int fcnt = 0, nrise = 0;
  assign miso = chain[TOT-1];

  always @(posedge sclk) if (!cs_n) begin
    chain <= {chain[TOT-2:0], mosi};
    nrise <= nrise + 1;
  end
  always @(posedge cs_n) if (rst_n) begin
    flog[fcnt[5:0]] <= chain;
    fcnt <= fcnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] seq_word(input int mask, input int d, input int k);
    if ((mask >> d) & 1) return 12'h400;
    if (k == 4) return 12'h200;
    return {2'(k), 2'b01, 8'(mask*29 + d*64 + k*17 + 1)};
  endfunction

  task automatic run(input bit sq, input logic [TOT-1:0] w, input logic [N_DEV-1:0] sk,
                     input logic [32*N_DEV-1:0] ch, input int nframes);
    int lo = 0, hi = 0, mviol = 0, cviol = 0, rviol = 0, hcs = 0, dcnt = 0, extra = 0;
    bit seen = 0, prev_s = 0, prev_m = 0, got = 0;
    int base = fcnt, r0 = nrise;
    @(negedge clk);
    req_seq = sq; req_words = w; req_skip = sk; req_chan = ch; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (!seen && !cs_n && !sclk) lo++;
      if (sclk) begin
        seen = 1; hi++;
        if (prev_s && mosi != prev_m) mviol++;
      end
      if (cs_n && sclk) cviol++;
      if (!cs_n && req_ready) rviol++;
      if (cs_n) hcs++; else hcs = 0;
      if (done) begin
        dcnt++;
        check(hcs == 2, "R8 done one cycle after cs_n rise", TOT'(hcs), TOT'(2));
        got = 1;
        break;
      end
      prev_s = sclk; prev_m = mosi;
      @(negedge clk);
    end
    if (!got) check(0, "R8 watchdog: no done", '0, TOT'(1));
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (done) extra++; end
    check(extra == 0 && dcnt == 1, "R8 single done pulse", TOT'(extra), '0);
    check(lo == CS_SETUP + CLK_DIV, "R6 cs_n fall to first sclk rise", TOT'(lo), TOT'(CS_SETUP + CLK_DIV));
    check(hi == nframes*TOT*CLK_DIV, "R6 sclk high phase length", TOT'(hi), TOT'(nframes*TOT*CLK_DIV));
    check(nrise - r0 == nframes*TOT, "R3 bit count", TOT'(nrise - r0), TOT'(nframes*TOT));
    check(mviol == 0, "R5 mosi stable while sclk high", TOT'(mviol), '0);
    check(cviol == 0, "R2 sclk only with cs_n low", TOT'(cviol), '0);
    check(rviol == 0, "R10 ready low while busy", TOT'(rviol), '0);
    check(fcnt - base == nframes, "R7 transaction count", TOT'(fcnt - base), TOT'(nframes));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TOT-1:0] prev_exp, exp, w;
    logic [32*N_DEV-1:0] ch;
    prev_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cs_n && !sclk && req_ready && !done && rdback == '0, "R1 reset state",
          {cs_n, sclk, req_ready, done, rdback[TOT-5:0]}, {4'b1010, {(TOT-4){1'b0}}});

    for (int mask = 0; mask < (1 << N_DEV); mask++) begin
      for (int d = 0; d < N_DEV; d++) begin
        w[d*12 +: 12] = 12'(mask*151 + d*997 + 33);
        exp[d*12 +: 12] = ((mask >> d) & 1) ? 12'h400 : w[d*12 +: 12];
      end
      run(1'b0, w, N_DEV'(mask), '0, 1);
      check(flog[(fcnt-1) % 64] == exp, mask == 0 ? "R3 chain order" : "R4 skip gives no-op",
            flog[(fcnt-1) % 64], exp);
      check(rdback == prev_exp, "R9 readback of previous chain contents", rdback, prev_exp);
      prev_exp = exp;
    end

    for (int mask = 0; mask < (1 << N_DEV); mask++) begin
      int b;
      for (int d = 0; d < N_DEV; d++)
        for (int c = 0; c < 4; c++) ch[d*32 + c*8 +: 8] = 8'(mask*29 + d*64 + c*17 + 1);
      b = fcnt;
      run(1'b1, '1, N_DEV'(mask), ch, 5);
      for (int k = 0; k < 5; k++) begin
        for (int d = 0; d < N_DEV; d++) exp[d*12 +: 12] = seq_word(mask, d, k);
        check(flog[(b+k) % 64] == exp, "R7 coordinated update word", flog[(b+k) % 64], exp);
        if (k == 3) prev_exp = exp;
      end
      check(rdback == prev_exp, "R9 readback after coordinated update", rdback, prev_exp);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule